// File: doc/BRIEF.md
# Counter-Array Time Base with Flags and Count-Source Selection

This block is the common time base for a set of compare/capture channels on an 8-bit microcontroller's register bus. It holds a 16-bit up-counter and two control bytes. The mode byte selects the count source, sets idle behaviour and enables the overflow interrupt. The control byte holds the run bit, the overflow flag and one event flag per channel. Software reaches four byte-wide locations through a simple write-enable bus with a combinational read path.

The counter can advance on four sources. Two are prescaled copies of the core clock, and their divisors halve when the six-clock strap is high. The third is the overflow pulse of a neighbouring timer. The fourth is falling edges on an external pin. That pin is brought in through a two-stage synchronizer and sampled at a bounded rate. Counting needs the run bit. It can also be frozen while the core is idle. Hardware sets the flags and only software clears them. The interrupt request follows the overflow flag when the enable is set.

Top module: `pca_timebase`

## Requirements
- R1: After reset the counter, both control bytes, `irq` and `wdt_en4` are all zero.
- R2: Source select 00 adds one every 12 clocks, or every 6 clocks when `clk6_mode` is 1.
- R3: Source select 01 adds one every 4 clocks, or every 2 clocks when `clk6_mode` is 1.
- R4: Source select 10 adds one for each clock in which `t0_ovf` is 1.
- R5: Source select 11 adds one for each falling edge of `ext_pin`. The pin passes through two flip-flops and is sampled every 8 clocks, or every 4 clocks when `clk6_mode` is 1. An edge is counted when each level lasts at least one sample interval.
- R6: While the run bit (control bit 6) is 0 the counter holds.
- R7: With counter-idle (mode bit 7) at 1, the counter holds while `idle` is 1. With counter-idle at 0, counting goes on during idle.
- R8: An increment from 0xFFFF gives 0x0000 and sets the overflow flag (control bit 7).
- R9: Writing 1 to control bit 7 sets the overflow flag. Writing 0 clears it. The flag stays set otherwise. A rollover in the same cycle as a clearing write leaves it set.
- R10: `irq` is 1 exactly when the overflow flag and the interrupt enable (mode bit 0) are both 1.
- R11: A 1 on `mod_evt[i]` sets control bit i (i = 0..4). The bit stays set until a write puts 0 there. The event wins over a simultaneous clearing write.
- R12: Address 0 is the mode byte: bit 7 counter-idle, bit 6 watchdog enable, bits 2:1 source, bit 0 interrupt enable. Address 1 is the control byte. Bits 5:3 of mode and bit 5 of control read 0 and ignore writes. `wdt_en4` follows mode bit 6.
- R13: Address 2 writes the low counter byte and address 3 the high byte. A byte write replaces that byte even if an increment falls in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 mode, 1 control, 2 count low, 3 count high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| clk6_mode | input | 1 | Strap: 1 selects the six-clock timing |
| t0_ovf | input | 1 | Neighbouring timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external count input |
| idle | input | 1 | Core idle indication |
| mod_evt | input | 5 | Per-channel match/capture pulses |
| count | output | 16 | Current counter value |
| irq | output | 1 | Overflow interrupt request |
| wdt_en4 | output | 1 | Watchdog enable for channel 4 |

## Verification
The bench builds the block with its default parameters: divisors 12, 4 and 8, five channels and an 8-bit bus. With these values a 240-clock window is a whole number of periods for both prescaled sources under both strap settings, so each expected count is an exact quotient. The external pin is swept over several half-periods that each reach a sample interval. All 32 event-flag patterns are walked, and rollover, flag races and byte writes are lined up cycle by cycle against timer-0 pulses.

// File: rtl/pca_timebase.sv
module pca_timebase #(
  parameter int DW       = 8,
  parameter int NMOD     = 5,
  parameter int SLOW_DIV = 12,
  parameter int FAST_DIV = 4,
  parameter int EXT_DIV  = 8,
  localparam int CW      = 2 * DW,
  localparam int SW      = $clog2(SLOW_DIV),
  localparam int FW      = $clog2(FAST_DIV) + 1,
  localparam int EW      = $clog2(EXT_DIV)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [1:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            clk6_mode,
  input  logic            t0_ovf,
  input  logic            ext_pin,
  input  logic            idle,
  input  logic [NMOD-1:0] mod_evt,
  output logic [CW-1:0]   count,
  output logic            irq,
  output logic            wdt_en4
);

  logic            cidl_q, wdte_q, ecf_q, cf_q, run_q;
  logic [1:0]      src_q;
  logic [NMOD-1:0] flag_q;
  logic [CW-1:0]   cnt_q;

  logic [SW-1:0] slow_q;
  logic [FW-1:0] fast_q;
  logic [EW-1:0] ext_q;
  logic          sync1_q, sync2_q, samp_q;

  wire wr_mode = bus_we && bus_addr == 2'd0;
  wire wr_ctrl = bus_we && bus_addr == 2'd1;
  wire wr_lo   = bus_we && bus_addr == 2'd2;
  wire wr_hi   = bus_we && bus_addr == 2'd3;

  wire [SW-1:0] slow_lim = clk6_mode ? SW'(SLOW_DIV / 2 - 1) : SW'(SLOW_DIV - 1);
  wire [FW-1:0] fast_lim = clk6_mode ? FW'(FAST_DIV / 2 - 1) : FW'(FAST_DIV - 1);
  wire [EW-1:0] ext_lim  = clk6_mode ? EW'(EXT_DIV / 2 - 1)  : EW'(EXT_DIV - 1);

  wire slow_tick = slow_q == '0;
  wire fast_tick = fast_q == '0;
  wire ext_stb   = ext_q == '0;
  wire ext_fall  = ext_stb && samp_q && !sync2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slow_q  <= '0;
      fast_q  <= '0;
      ext_q   <= '0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      samp_q  <= 1'b0;
    end else begin
      slow_q  <= (slow_q >= slow_lim) ? '0 : slow_q + 1'b1;
      fast_q  <= (fast_q >= fast_lim) ? '0 : fast_q + 1'b1;
      ext_q   <= (ext_q >= ext_lim) ? '0 : ext_q + 1'b1;
      sync1_q <= ext_pin;
      sync2_q <= sync1_q;
      if (ext_stb) samp_q <= sync2_q;
    end
  end

  logic src_tick;
  always_comb begin
    case (src_q)
      2'd0:    src_tick = slow_tick;
      2'd1:    src_tick = fast_tick;
      2'd2:    src_tick = t0_ovf;
      default: src_tick = ext_fall;
    endcase
  end

  wire inc = run_q && !(cidl_q && idle) && src_tick;
  wire ovf = inc && (&cnt_q);

  logic [CW-1:0] cnt_d;
  always_comb begin
    cnt_d = cnt_q + CW'(inc);
    if (wr_lo) cnt_d[DW-1:0]  = bus_wdata;
    if (wr_hi) cnt_d[CW-1:DW] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cidl_q <= 1'b0;
      wdte_q <= 1'b0;
      src_q  <= 2'd0;
      ecf_q  <= 1'b0;
      cf_q   <= 1'b0;
      run_q  <= 1'b0;
      flag_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_mode) begin
        cidl_q <= bus_wdata[7];
        wdte_q <= bus_wdata[6];
        src_q  <= bus_wdata[2:1];
        ecf_q  <= bus_wdata[0];
      end
      if (wr_ctrl) run_q <= bus_wdata[6];
      cf_q   <= (wr_ctrl ? bus_wdata[7] : cf_q) | ovf;
      flag_q <= (wr_ctrl ? bus_wdata[NMOD-1:0] : flag_q) | mod_evt;
      cnt_q  <= cnt_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      2'd0: begin
        bus_rdata[7]   = cidl_q;
        bus_rdata[6]   = wdte_q;
        bus_rdata[2:1] = src_q;
        bus_rdata[0]   = ecf_q;
      end
      2'd1: begin
        bus_rdata[7]        = cf_q;
        bus_rdata[6]        = run_q;
        bus_rdata[NMOD-1:0] = flag_q;
      end
      2'd2:    bus_rdata = cnt_q[DW-1:0];
      default: bus_rdata = cnt_q[CW-1:DW];
    endcase
  end

  assign count   = cnt_q;
  assign irq     = cf_q && ecf_q;
  assign wdt_en4 = wdte_q;

endmodule

// File: rtl/pca_timebase_sva.sv
module pca_timebase_sva #(
  parameter int DW   = 8,
  parameter int NMOD = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_we,
  input logic [1:0]      bus_addr,
  input logic [DW-1:0]   bus_rdata,
  input logic            idle,
  input logic [NMOD-1:0] mod_evt,
  input logic [2*DW-1:0] count,
  input logic            irq,
  input logic            cf,
  input logic            run,
  input logic            cidl,
  input logic [NMOD-1:0] flags
);

  wire cnt_wr  = bus_we && bus_addr[1];
  wire ctrl_wr = bus_we && bus_addr == 2'd1;

  assert_halt_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(count));

  assert_idle_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cidl && idle && !cnt_wr) |=> $stable(count));

  assert_rollover_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((&count) && !cnt_wr) |=> ((&count) || (count == '0 && cf)));

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cf && !ctrl_wr) |=> cf);

  assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> cf);

  assert_evt_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|mod_evt) |=> ((flags & $past(mod_evt)) == $past(mod_evt)));

  assert_reserved_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == 2'd0) |-> (bus_rdata[5:3] == 3'b000));

endmodule

bind pca_timebase pca_timebase_sva #(.DW(DW), .NMOD(NMOD)) sva_i (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .idle(idle), .mod_evt(mod_evt), .count(count),
  .irq(irq), .cf(cf_q), .run(run_q), .cidl(cidl_q), .flags(flag_q)
);

// File: tb/pca_timebase_tb.sv
module pca_timebase_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic clk6_mode = 1'b0, t0_ovf = 1'b0, ext_pin = 1'b1, idle = 1'b0;
  logic [4:0] mod_evt = 5'd0;
  logic [15:0] count;
  logic irq, wdt_en4;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pca_timebase dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk6_mode(clk6_mode),
    .t0_ovf(t0_ovf), .ext_pin(ext_pin), .idle(idle), .mod_evt(mod_evt),
    .count(count), .irq(irq), .wdt_en4(wdt_en4)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [7:0] mode(input bit ci, input bit wd, input logic [1:0] s, input bit en);
    return {ci, wd, 3'b000, s, en};
  endfunction

  task automatic measure(input int cyc, output int diff);
    logic [15:0] c0;
    @(negedge clk);
    c0 = count;
    repeat (cyc) @(negedge clk);
    diff = int'(16'(count - c0));
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, r); chk("R1 mode", r, 0);
    rd(2'd1, r); chk("R1 ctrl", r, 0);
    chk("R1 count", count, 0);
    chk("R1 irq", irq, 0);
    chk("R1 wdt", wdt_en4, 0);

    for (int s = 0; s < 2; s++) begin
      clk6_mode = s[0];
      wr(2'd0, mode(0, 0, 2'd0, 0)); wr(2'd1, 8'h40);
      measure(240, d); chk(s ? "R2 slow 6clk" : "R2 slow 12clk", d, 240 / (s ? 6 : 12));
      wr(2'd0, mode(0, 0, 2'd1, 0));
      measure(240, d); chk(s ? "R3 fast 6clk" : "R3 fast 12clk", d, 240 / (s ? 2 : 4));
    end

    clk6_mode = 1'b0;
    wr(2'd0, mode(0, 0, 2'd2, 0));
    for (int gap = 3; gap <= 10; gap += 7) begin
      logic [15:0] c0;
      @(negedge clk); c0 = count;
      for (int k = 0; k < 240; k++) begin
        t0_ovf = (k % gap) == 0;
        @(negedge clk);
      end
      t0_ovf = 1'b0;
      chk("R4 timer pulses", int'(16'(count - c0)), (240 + gap - 1) / gap);
    end

    wr(2'd0, mode(0, 0, 2'd3, 0));
    for (int s = 0; s < 2; s++) begin
      clk6_mode = s[0];
      for (int h = 8; h <= 16; h += 4) begin
        logic [15:0] c0;
        ext_pin = 1'b1;
        repeat (20) @(negedge clk);
        c0 = count;
        for (int k = 0; k < 10; k++) begin
          ext_pin = 1'b1; repeat (h) @(negedge clk);
          ext_pin = 1'b0; repeat (h) @(negedge clk);
        end
        ext_pin = 1'b1;
        repeat (40) @(negedge clk);
        chk("R5 ext edges", int'(16'(count - c0)), 10);
      end
    end

    clk6_mode = 1'b0;
    wr(2'd0, mode(0, 0, 2'd1, 0)); wr(2'd1, 8'h00);
    measure(40, d); chk("R6 run off", d, 0);
    wr(2'd1, 8'h40);
    idle = 1'b1;
    wr(2'd0, mode(1, 0, 2'd1, 0));
    measure(40, d); chk("R7 idle gated", d, 0);
    wr(2'd0, mode(0, 0, 2'd1, 0));
    measure(40, d); chk("R7 idle free", d, 10);
    idle = 1'b0;
    wr(2'd0, mode(1, 0, 2'd1, 0));
    measure(40, d); chk("R7 not idle", d, 10);

    wr(2'd0, mode(0, 0, 2'd2, 0));
    wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    chk("R13 count load", count, 16'hFFFF);
    @(negedge clk);
    t0_ovf = 1'b1; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
    @(negedge clk);
    t0_ovf = 1'b0; bus_we = 1'b0;
    chk("R8 wrap", count, 0);
    rd(2'd1, r); chk("R9 hw set wins", r[7], 1);
    chk("R10 irq masked", irq, 0);
    wr(2'd0, mode(0, 0, 2'd2, 1));
    chk("R10 irq enabled", irq, 1);
    wr(2'd1, 8'h40);
    rd(2'd1, r); chk("R9 sw clear", r[7], 0);
    chk("R10 irq after clear", irq, 0);
    wr(2'd1, 8'hC0);
    rd(2'd1, r); chk("R9 sw set", r[7], 1);
    chk("R10 irq sw set", irq, 1);
    repeat (3) @(negedge clk);
    rd(2'd1, r); chk("R9 sticky", r[7], 1);
    wr(2'd1, 8'h40);

    @(negedge clk);
    t0_ovf = 1'b1; bus_we = 1'b1; bus_addr = 2'd2; bus_wdata = 8'h55;
    @(negedge clk);
    t0_ovf = 1'b0; bus_we = 1'b0;
    chk("R13 low write wins", count, 16'h0055);
    wr(2'd3, 8'hA3);
    chk("R13 high write", count, 16'hA355);
    rd(2'd2, r); chk("R13 read low", r, 8'h55);
    rd(2'd3, r); chk("R13 read high", r, 8'hA3);

    for (int p = 0; p < 32; p++) begin
      wr(2'd1, 8'h40);
      @(negedge clk); mod_evt = p[4:0];
      @(negedge clk); mod_evt = 5'd0;
      repeat (2) @(negedge clk);
      rd(2'd1, r); chk("R11 flag pattern", r[4:0], p);
    end
    wr(2'd1, 8'h40);
    @(negedge clk);
    mod_evt = 5'b00100; bus_we = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h40;
    @(negedge clk);
    mod_evt = 5'd0; bus_we = 1'b0;
    rd(2'd1, r); chk("R11 event wins", r[4:0], 5'b00100);
    wr(2'd1, 8'h40);
    rd(2'd1, r); chk("R11 sw clear", r[4:0], 0);

    wr(2'd0, 8'hFF);
    rd(2'd0, r); chk("R12 mode reserved", r, 8'hC7);
    chk("R12 wdt on", wdt_en4, 1);
    wr(2'd0, 8'h00);
    chk("R12 wdt off", wdt_en4, 0);
    wr(2'd0, mode(0, 0, 2'd2, 0));
    wr(2'd1, 8'hFF);
    rd(2'd1, r); chk("R12 ctrl reserved", r, 8'hDF);
    wr(2'd1, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule